// File: doc/BRIEF.md
# SMBus Block-Transfer Buffer Sequencer

This block sits between the register decode of an SMBus host controller and its serial bus master. It owns a message buffer, an index into it and a block-data holding register. It sequences the two kinds of multi-byte transfer: SMBus block write and read, and the I2C-style block read that sends an offset byte and then reads back after a repeated start. Decoded host actions arrive as single-cycle strobes, at most one per cycle. These are a start command, a write or read of the block-data register, and a clear of the byte-done status bit. The last-byte flag, the buffered-mode select and the count held in the data0 register come in as levels.

Two modes exist. In byte-by-byte mode, software moves one byte per handshake through the block-data register and the byte-done status bit. In buffered mode, software fills or drains the whole buffer through auto-incrementing block-data accesses, and the bus transfer runs on the complete message. Status changes leave the block as one-cycle set pulses, for the register decode to merge into its status register. Busy is a level. Bus work leaves as one-cycle request pulses. The bus master reads and fills the buffer through its own index port and finishes each request with a response strobe.

Top module: `smb_blk_seq`

## Requirements
- R1: After reset, busy is 0, the index is 0, no pulse output is asserted and the block-data read value is 0.
- R2: A byte-by-byte write start (start with the I2C select at 0, the read select at 0 and buffered mode at 0) copies the block-data register into buffer entry 0 and clears the index. It raises busy and gives one byte-done pulse.
- R3: In a byte-by-byte write, each byte-done clear advances the index. If the new index is not the count, the block-data register is stored at the new index and byte-done pulses again. If the new index equals the count, one block-write request is issued with the count as its argument, and the index returns to 0. The bus response then gives a done pulse, or a device-error pulse on error, and busy drops.
- R4: A byte-by-byte read start issues a block-read request. The successful response gives a count-update pulse that carries the returned count, presents buffer entry 0 on the read value and pulses byte-done. Each later byte-done clear presents the next entry and pulses byte-done.
- R5: A byte-by-byte clear with the last-byte flag at 1 presents the next entry, clears the index, pulses done and drops busy.
- R6: In buffered mode, host block-data writes store at the index and increment it. A write start with index not equal to the count gives a device-error pulse, clears the index and leaves busy at 0. A matching index issues the block-write request.
- R7: In a buffered read, the successful response pulses count-update and done together, and busy stays 1. The read value shows the entry at the index, and each host block-data read advances the index. The read that brings the index to the returned count drops busy and clears the index.
- R8: An I2C block read start ignores the read select. It issues an offset request whose argument is the offset input. Its response byte appears on the read value with a byte-done pulse, and each later clear issues a receive request with the final flag at 0.
- R9: A clear with the last-byte flag at 1 during an I2C block read issues a receive request with the final flag at 1, which asks for a NACK and a stop. Its response byte appears on the read value, with a done pulse, and busy drops.
- R10: The index wraps from 31 (buffer size minus one) to 0.
- R11: A start while a host handshake is in progress abandons that transfer and clears the index before the new one begins. If an I2C block read was open, a stop request is pulsed in the same cycle.
- R12: A start that arrives while a bus request awaits its response is ignored, and busy stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evStart | input | 1 | Host start strobe |
| startI2c | input | 1 | Start selects the I2C block read |
| startRead | input | 1 | Address read/write bit (1 = read) |
| bufMode | input | 1 | 1 = buffered mode, 0 = byte-by-byte |
| lastByte | input | 1 | Last-byte control flag |
| countIn | input | CNT_W | Byte count from the data0 register |
| offsetIn | input | DATA_W | Offset byte from the data1 register |
| evBlkWr | input | 1 | Host write of block data |
| hostWrData | input | DATA_W | Data of that write |
| evBlkRd | input | 1 | Host read of block data |
| evByteDoneClr | input | 1 | Host clear of byte-done |
| blkRdData | output | DATA_W | Value the host reads from block data |
| busy | output | 1 | Transfer in progress |
| setByteDone | output | 1 | Set pulse for byte-done |
| setDone | output | 1 | Set pulse for transfer complete |
| setDevErr | output | 1 | Set pulse for device error |
| countWe | output | 1 | Pulse: load data0 with countOut |
| countOut | output | CNT_W | Count returned by a block read |
| reqWrBlk | output | 1 | Request: block write of reqArg bytes from the buffer |
| reqRdBlk | output | 1 | Request: block read into the buffer |
| reqOffset | output | 1 | Request: write offset reqArg, repeated start, receive one byte |
| reqRecv | output | 1 | Request: receive one byte |
| reqFinal | output | 1 | With reqRecv: NACK and stop after the byte |
| reqStop | output | 1 | Request: stop the open I2C read |
| reqArg | output | CNT_W | Argument of the current request |
| mstIdx | input | IDX_W | Bus master buffer index |
| mstData | output | DATA_W | Buffer entry at mstIdx |
| rspValid | input | 1 | Bus master response strobe |
| rspErr | input | 1 | Response reports an error |
| rspData | input | DATA_W | Received byte, or the count for a block read |
| rspWe | input | 1 | Bus master writes rspData to buffer entry mstIdx |

## Verification
Every pulse and request appears in the cycle after the clock edge that samples its host strobe or bus response. Busy, the index and the read value change at that same edge. The buffer read port toward the bus master is combinational and is valid within the cycle. The monitor samples the pulse outputs 2 ns after each rising edge, so it sees each one-cycle pulse exactly once and compares it, with its argument, against the queued expectations in order. Level checks on busy and the read value are made at the falling edge that follows each strobe, after the edge that updated them.

// File: rtl/smb_blk_pkg.sv
package smb_blk_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_BW,
    ST_BR,
    ST_BUFRD,
    ST_I2C,
    ST_WAIT_WR,
    ST_WAIT_RD,
    ST_WAIT_OFS,
    ST_WAIT_RCV,
    ST_WAIT_LAST
  } seqState_e;

  typedef enum logic [1:0] {
    IDX_HOLD,
    IDX_CLR,
    IDX_INC
  } idxOp_e;

  typedef enum logic [2:0] {
    BLK_HOLD,
    BLK_HOST,
    BLK_BUF_NEXT,
    BLK_BUF_ZERO,
    BLK_RSP
  } blkSel_e;

  typedef enum logic [1:0] {
    BUF_NONE,
    BUF_BLK_ZERO,
    BUF_BLK_NEXT,
    BUF_HOST_IDX
  } bufSel_e;

  typedef struct packed {
    idxOp_e  idxOp;
    blkSel_e blkSel;
    bufSel_e bufSel;
    logic    cntLoad;
  } dpCmd_t;

endpackage

// File: rtl/smb_blk_dp.sv
module smb_blk_dp
  import smb_blk_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic              bufView,
  input  logic [DATA_W-1:0] hostData,
  input  logic [DATA_W-1:0] rspData,
  input  logic              rspWe,
  input  logic [IDX_W-1:0]  mstIdx,
  input  logic [CNT_W-1:0]  countIn,
  output logic [DATA_W-1:0] mstData,
  output logic [DATA_W-1:0] rdData,
  output logic [CNT_W-1:0]  countOut,
  output logic              idxEqCnt,
  output logic              idxNextEqCnt,
  output logic              idxNextEqRdCnt
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  idxNext;
  logic [DATA_W-1:0] blkReg;
  logic [CNT_W-1:0]  cntReg;

  // wrap at the last entry
  assign idxNext = (idx == IDX_W'(DEPTH - 1)) ? '0 : idx + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx <= '0;
    end else begin
      case (cmd.idxOp)
        IDX_CLR: idx <= '0;
        IDX_INC: idx <= idxNext;
        default: idx <= idx;
      endcase
    end
  end

  // bus master deposits take priority over host-side writes
  always_ff @(posedge clk) begin
    if (rspWe) begin
      mem[mstIdx] <= rspData;
    end else begin
      case (cmd.bufSel)
        BUF_BLK_ZERO: mem[0]       <= blkReg;
        BUF_BLK_NEXT: mem[idxNext] <= blkReg;
        BUF_HOST_IDX: mem[idx]     <= hostData;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blkReg <= '0;
      cntReg <= '0;
    end else begin
      case (cmd.blkSel)
        BLK_HOST:     blkReg <= hostData;
        BLK_BUF_NEXT: blkReg <= mem[idxNext];
        BLK_BUF_ZERO: blkReg <= mem[0];
        BLK_RSP:      blkReg <= rspData;
        default:      blkReg <= blkReg;
      endcase
      if (cmd.cntLoad) cntReg <= CNT_W'(rspData);
    end
  end

  assign mstData        = mem[mstIdx];
  assign rdData         = bufView ? mem[idx] : blkReg;
  assign countOut       = cntReg;
  assign idxEqCnt       = (CNT_W'(idx) == countIn);
  assign idxNextEqCnt   = (CNT_W'(idxNext) == countIn);
  assign idxNextEqRdCnt = (CNT_W'(idxNext) == cntReg);

  // R6: a buffered host write lands at the index it was issued to
  property bufHostWrite;
    @(posedge clk) disable iff (!rstN)
      (cmd.bufSel == BUF_HOST_IDX && !rspWe) |=> (mem[$past(idx)] == $past(hostData));
  endproperty
  assert_buf_host_write_R6: assert property (bufHostWrite);

endmodule

// File: rtl/smb_blk_ctrl.sv
module smb_blk_ctrl
  import smb_blk_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evStart,
  input  logic              startI2c,
  input  logic              startRead,
  input  logic              bufMode,
  input  logic              lastByte,
  input  logic [CNT_W-1:0]  countIn,
  input  logic [DATA_W-1:0] offsetIn,
  input  logic              evBlkWr,
  input  logic              evBlkRd,
  input  logic              evByteDoneClr,
  input  logic              rspValid,
  input  logic              rspErr,
  input  logic              idxEqCnt,
  input  logic              idxNextEqCnt,
  input  logic              idxNextEqRdCnt,
  output dpCmd_t            cmd,
  output logic              bufView,
  output logic              busy,
  output logic              setByteDone,
  output logic              setDone,
  output logic              setDevErr,
  output logic              countWe,
  output logic              reqWrBlk,
  output logic              reqRdBlk,
  output logic              reqOffset,
  output logic              reqRecv,
  output logic              reqFinal,
  output logic              reqStop,
  output logic [CNT_W-1:0]  reqArg
);

  seqState_e st, stNext;
  logic nBd, nDone, nErr, nCnt, nWr, nRd, nOfs, nRecv, nFinal, nStop;
  logic [CNT_W-1:0] nArg;
  logic isAct, isWait, i2cOpen, startMatch;

  assign isAct   = st inside {ST_BW, ST_BR, ST_BUFRD, ST_I2C};
  assign isWait  = st inside {ST_WAIT_WR, ST_WAIT_RD, ST_WAIT_OFS, ST_WAIT_RCV, ST_WAIT_LAST};
  assign i2cOpen = st inside {ST_I2C, ST_WAIT_OFS, ST_WAIT_RCV, ST_WAIT_LAST};
  assign bufView = bufMode && !i2cOpen;
  assign busy    = (st != ST_IDLE);
  // an abandoned transfer restarts from index 0
  assign startMatch = isAct ? (countIn == '0) : idxEqCnt;

  always_comb begin
    stNext      = st;
    cmd.idxOp   = IDX_HOLD;
    cmd.blkSel  = BLK_HOLD;
    cmd.bufSel  = BUF_NONE;
    cmd.cntLoad = 1'b0;
    {nBd, nDone, nErr, nCnt, nWr, nRd, nOfs, nRecv, nFinal, nStop} = '0;
    nArg = '0;

    if (evBlkWr) begin
      if (bufMode) begin
        cmd.bufSel = BUF_HOST_IDX;
        cmd.idxOp  = IDX_INC;
      end else begin
        cmd.blkSel = BLK_HOST;
      end
    end

    if (evBlkRd && bufView) begin
      cmd.idxOp = IDX_INC;
      if (st == ST_BUFRD && idxNextEqRdCnt) begin
        cmd.idxOp = IDX_CLR;
        stNext    = ST_IDLE;
      end
    end

    if (evStart && !isWait) begin
      nStop     = (st == ST_I2C);
      cmd.idxOp = IDX_CLR;
      if (startI2c) begin
        nOfs   = 1'b1;
        nArg   = CNT_W'(offsetIn);
        stNext = ST_WAIT_OFS;
      end else if (!startRead) begin
        if (!bufMode) begin
          cmd.bufSel = BUF_BLK_ZERO;
          nBd        = 1'b1;
          stNext     = ST_BW;
        end else if (startMatch) begin
          nWr    = 1'b1;
          nArg   = countIn;
          stNext = ST_WAIT_WR;
        end else begin
          nErr   = 1'b1;
          stNext = ST_IDLE;
        end
      end else begin
        nRd    = 1'b1;
        stNext = ST_WAIT_RD;
      end
    end else if (evByteDoneClr) begin
      case (st)
        ST_BW: begin
          if (idxNextEqCnt) begin
            nWr       = 1'b1;
            nArg      = countIn;
            cmd.idxOp = IDX_CLR;
            stNext    = ST_WAIT_WR;
          end else begin
            cmd.idxOp  = IDX_INC;
            cmd.bufSel = BUF_BLK_NEXT;
            nBd        = 1'b1;
          end
        end
        ST_BR: begin
          cmd.blkSel = BLK_BUF_NEXT;
          if (lastByte) begin
            cmd.idxOp = IDX_CLR;
            nDone     = 1'b1;
            stNext    = ST_IDLE;
          end else begin
            cmd.idxOp = IDX_INC;
            nBd       = 1'b1;
          end
        end
        ST_I2C: begin
          nRecv  = 1'b1;
          nFinal = lastByte;
          stNext = lastByte ? ST_WAIT_LAST : ST_WAIT_RCV;
        end
        default: ;
      endcase
    end

    if (rspValid) begin
      case (st)
        ST_WAIT_WR: begin
          nErr   = rspErr;
          nDone  = !rspErr;
          stNext = ST_IDLE;
        end
        ST_WAIT_RD: begin
          cmd.idxOp = IDX_CLR;
          if (rspErr) begin
            nErr   = 1'b1;
            stNext = ST_IDLE;
          end else begin
            cmd.cntLoad = 1'b1;
            nCnt        = 1'b1;
            if (bufMode) begin
              nDone  = 1'b1;
              stNext = ST_BUFRD;
            end else begin
              cmd.blkSel = BLK_BUF_ZERO;
              nBd        = 1'b1;
              stNext     = ST_BR;
            end
          end
        end
        ST_WAIT_OFS, ST_WAIT_RCV: begin
          if (rspErr) begin
            nErr   = 1'b1;
            stNext = ST_IDLE;
          end else begin
            cmd.blkSel = BLK_RSP;
            nBd        = 1'b1;
            stNext     = ST_I2C;
          end
        end
        ST_WAIT_LAST: begin
          cmd.idxOp = IDX_CLR;
          nErr      = rspErr;
          nDone     = !rspErr;
          if (!rspErr) cmd.blkSel = BLK_RSP;
          stNext = ST_IDLE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st <= ST_IDLE;
      {setByteDone, setDone, setDevErr, countWe, reqWrBlk, reqRdBlk,
       reqOffset, reqRecv, reqFinal, reqStop} <= '0;
      reqArg <= '0;
    end else begin
      st          <= stNext;
      setByteDone <= nBd;
      setDone     <= nDone;
      setDevErr   <= nErr;
      countWe     <= nCnt;
      reqWrBlk    <= nWr;
      reqRdBlk    <= nRd;
      reqOffset   <= nOfs;
      reqRecv     <= nRecv;
      reqFinal    <= nFinal;
      reqStop     <= nStop;
      reqArg      <= nArg;
    end
  end

  // R2: byte-done is only ever raised while a transfer is open
  assert_bytedone_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    setByteDone |-> busy);

  // R3: a block-write request leaves the sequencer waiting, not done
  assert_wr_waits_R3: assert property (@(posedge clk) disable iff (!rstN)
    reqWrBlk |-> (busy && !setDone));

  // R8: at most one bus request per cycle
  assert_one_req_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({reqWrBlk, reqRdBlk, reqOffset, reqRecv}));

  // R9: the final flag only qualifies a receive request
  assert_final_recv_R9: assert property (@(posedge clk) disable iff (!rstN)
    reqFinal |-> reqRecv);

  // R11: the abandon stop comes with the new transfer already running
  assert_stop_busy_R11: assert property (@(posedge clk) disable iff (!rstN)
    reqStop |-> busy);

  // R12: a start during a bus wait does not end the transfer
  assert_wait_start_R12: assert property (@(posedge clk) disable iff (!rstN)
    (isWait && evStart && !rspValid) |=> busy);

endmodule

// File: rtl/smb_blk_seq.sv
module smb_blk_seq
  import smb_blk_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evStart,
  input  logic              startI2c,
  input  logic              startRead,
  input  logic              bufMode,
  input  logic              lastByte,
  input  logic [CNT_W-1:0]  countIn,
  input  logic [DATA_W-1:0] offsetIn,
  input  logic              evBlkWr,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic              evBlkRd,
  input  logic              evByteDoneClr,
  output logic [DATA_W-1:0] blkRdData,
  output logic              busy,
  output logic              setByteDone,
  output logic              setDone,
  output logic              setDevErr,
  output logic              countWe,
  output logic [CNT_W-1:0]  countOut,
  output logic              reqWrBlk,
  output logic              reqRdBlk,
  output logic              reqOffset,
  output logic              reqRecv,
  output logic              reqFinal,
  output logic              reqStop,
  output logic [CNT_W-1:0]  reqArg,
  input  logic [IDX_W-1:0]  mstIdx,
  output logic [DATA_W-1:0] mstData,
  input  logic              rspValid,
  input  logic              rspErr,
  input  logic [DATA_W-1:0] rspData,
  input  logic              rspWe
);

  dpCmd_t dpCmd;
  logic   bufView, idxEqCnt, idxNextEqCnt, idxNextEqRdCnt;

  smb_blk_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .evStart(evStart), .startI2c(startI2c), .startRead(startRead),
    .bufMode(bufMode), .lastByte(lastByte), .countIn(countIn),
    .offsetIn(offsetIn), .evBlkWr(evBlkWr), .evBlkRd(evBlkRd),
    .evByteDoneClr(evByteDoneClr), .rspValid(rspValid), .rspErr(rspErr),
    .idxEqCnt(idxEqCnt), .idxNextEqCnt(idxNextEqCnt),
    .idxNextEqRdCnt(idxNextEqRdCnt),
    .cmd(dpCmd), .bufView(bufView), .busy(busy),
    .setByteDone(setByteDone), .setDone(setDone), .setDevErr(setDevErr),
    .countWe(countWe), .reqWrBlk(reqWrBlk), .reqRdBlk(reqRdBlk),
    .reqOffset(reqOffset), .reqRecv(reqRecv), .reqFinal(reqFinal),
    .reqStop(reqStop), .reqArg(reqArg)
  );

  smb_blk_dp #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .cmd(dpCmd), .bufView(bufView),
    .hostData(hostWrData), .rspData(rspData), .rspWe(rspWe),
    .mstIdx(mstIdx), .countIn(countIn), .mstData(mstData),
    .rdData(blkRdData), .countOut(countOut), .idxEqCnt(idxEqCnt),
    .idxNextEqCnt(idxNextEqCnt), .idxNextEqRdCnt(idxNextEqRdCnt)
  );

endmodule

// File: tb/sim_smb_blk_seq.sv
`timescale 1ns/1ps
module sim_smb_blk_seq;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic evStart = 0, startI2c = 0, startRead = 0, bufMode = 0, lastByte = 0;
  logic [7:0] countIn = 0, offsetIn = 0, hostWrData = 0, rspData = 0;
  logic evBlkWr = 0, evBlkRd = 0, evByteDoneClr = 0;
  logic [4:0] mstIdx = 0;
  logic rspValid = 0, rspErr = 0, rspWe = 0;
  logic [7:0] blkRdData, countOut, reqArg, mstData;
  logic busy, setByteDone, setDone, setDevErr, countWe;
  logic reqWrBlk, reqRdBlk, reqOffset, reqRecv, reqFinal, reqStop;

  always #4 clk = ~clk;

  smb_blk_seq u0 (
    .clk(clk), .rstN(rstN), .evStart(evStart), .startI2c(startI2c),
    .startRead(startRead), .bufMode(bufMode), .lastByte(lastByte),
    .countIn(countIn), .offsetIn(offsetIn), .evBlkWr(evBlkWr),
    .hostWrData(hostWrData), .evBlkRd(evBlkRd), .evByteDoneClr(evByteDoneClr),
    .blkRdData(blkRdData), .busy(busy), .setByteDone(setByteDone),
    .setDone(setDone), .setDevErr(setDevErr), .countWe(countWe),
    .countOut(countOut), .reqWrBlk(reqWrBlk), .reqRdBlk(reqRdBlk),
    .reqOffset(reqOffset), .reqRecv(reqRecv), .reqFinal(reqFinal),
    .reqStop(reqStop), .reqArg(reqArg), .mstIdx(mstIdx), .mstData(mstData),
    .rspValid(rspValid), .rspErr(rspErr), .rspData(rspData), .rspWe(rspWe)
  );

  // item pulse bits: {byteDone, done, devErr, countWe, wr, rd, offset, recv, final, stop}
  localparam logic [9:0] P_BD = 10'h200, P_DN = 10'h100, P_ER = 10'h080,
                         P_CN = 10'h040, P_WR = 10'h020, P_RD = 10'h010,
                         P_OF = 10'h008, P_RC = 10'h004, P_FN = 10'h002,
                         P_ST = 10'h001;

  logic [17:0] expQ[$];
  string       tagQ[$];
  int compared = 0, mismatched = 0;
  bit finished = 0;

  task automatic expectItem(input logic [9:0] p, input logic [7:0] d, input string tag);
    expQ.push_back({p, d});
    tagQ.push_back(tag);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compares every pulse cycle against the queue
  logic [9:0]  mPulse;
  logic [7:0]  mData;
  logic [17:0] mExp;
  string       mTag;
  always @(posedge clk) begin
    #2;
    if (rstN && !finished) begin
      mPulse = {setByteDone, setDone, setDevErr, countWe, reqWrBlk, reqRdBlk,
                reqOffset, reqRecv, reqFinal, reqStop};
      if (mPulse != 0) begin
        mData = countWe ? countOut : ((reqWrBlk || reqOffset) ? reqArg : 8'h00);
        compared++;
        if (expQ.size() == 0) begin
          mismatched++;
          $display("FAIL R1 unexpected item: actual %0h expected none", {mPulse, mData});
        end else begin
          mExp = expQ.pop_front();
          mTag = tagQ.pop_front();
          if (mExp != {mPulse, mData}) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", mTag, {mPulse, mData}, mExp);
          end
        end
      end
    end
  end

  task automatic step(); @(negedge clk); endtask
  task automatic hostWr(input logic [7:0] d);
    evBlkWr = 1; hostWrData = d; step(); evBlkWr = 0;
  endtask
  task automatic hostRd(); evBlkRd = 1; step(); evBlkRd = 0; endtask
  task automatic bdClr(); evByteDoneClr = 1; step(); evByteDoneClr = 0; endtask
  task automatic start(input logic i2c, input logic rd);
    startI2c = i2c; startRead = rd; evStart = 1; step(); evStart = 0;
  endtask
  task automatic rsp(input logic err, input logic [7:0] d);
    rspValid = 1; rspErr = err; rspData = d; step(); rspValid = 0; rspErr = 0;
  endtask
  task automatic dep(input logic [4:0] i, input logic [7:0] d);
    rspWe = 1; mstIdx = i; rspData = d; step(); rspWe = 0;
  endtask
  task automatic mstChk(input logic [4:0] i, input logic [7:0] e, input string tag);
    mstIdx = i; #1; chk(tag, mstData, e);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      mismatched++;
      $display("FAIL watchdog: actual hung expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rstN = 1;
    step();
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 rdData", blkRdData, 0);
    step();

    // R2/R3 byte-by-byte write of 3 bytes
    bufMode = 0; countIn = 3;
    hostWr(8'hA1);
    expectItem(P_BD, 0, "R2 start byte-done");
    start(0, 0);
    chk("R2 busy", busy, 1);
    hostWr(8'hB2);
    expectItem(P_BD, 0, "R3 byte-done 1");
    bdClr();
    hostWr(8'hC3);
    expectItem(P_BD, 0, "R3 byte-done 2");
    bdClr();
    expectItem(P_WR, 3, "R3 write request");
    bdClr();
    mstChk(0, 8'hA1, "R2 buf0");
    mstChk(1, 8'hB2, "R3 buf1");
    mstChk(2, 8'hC3, "R3 buf2");
    start(0, 0);              // R12 ignored while waiting
    chk("R12 busy held", busy, 1);
    expectItem(P_DN, 0, "R3 done");
    rsp(0, 0);
    chk("R3 busy low", busy, 0);

    // R6 buffered write: mismatch then match with bus error
    bufMode = 1;
    hostWr(8'h01); hostWr(8'h02);
    expectItem(P_ER, 0, "R6 count mismatch");
    start(0, 0);
    chk("R6 busy after mismatch", busy, 0);
    hostWr(8'h11); hostWr(8'h22); hostWr(8'h33);
    expectItem(P_WR, 3, "R6 write request");
    start(0, 0);
    mstChk(0, 8'h11, "R6 buf0");
    mstChk(2, 8'h33, "R6 buf2");
    expectItem(P_ER, 0, "R3 bus error");
    rsp(1, 0);
    chk("R3 busy after error", busy, 0);

    // R4/R5 byte-by-byte read of 4 bytes
    bufMode = 0;
    expectItem(P_RD, 0, "R4 read request");
    start(0, 1);
    dep(0, 8'h10); dep(1, 8'h20); dep(2, 8'h30); dep(3, 8'h40);
    expectItem(P_CN | P_BD, 4, "R4 count and byte-done");
    rsp(0, 4);
    chk("R4 first byte", blkRdData, 8'h10);
    expectItem(P_BD, 0, "R4 byte-done 2");
    bdClr();
    chk("R4 second byte", blkRdData, 8'h20);
    expectItem(P_BD, 0, "R4 byte-done 3");
    bdClr();
    chk("R4 third byte", blkRdData, 8'h30);
    lastByte = 1;
    expectItem(P_DN, 0, "R5 done");
    bdClr();
    lastByte = 0;
    chk("R5 last byte", blkRdData, 8'h40);
    chk("R5 busy low", busy, 0);

    // R7 buffered read of 3 bytes
    bufMode = 1;
    expectItem(P_RD, 0, "R7 read request");
    start(0, 1);
    dep(0, 8'h05); dep(1, 8'h06); dep(2, 8'h07);
    expectItem(P_CN | P_DN, 3, "R7 count and done");
    rsp(0, 3);
    chk("R7 busy held", busy, 1);
    chk("R7 entry0", blkRdData, 8'h05);
    hostRd();
    chk("R7 entry1", blkRdData, 8'h06);
    hostRd();
    chk("R7 entry2", blkRdData, 8'h07);
    hostRd();
    chk("R7 busy low at count", busy, 0);
    chk("R7 index reset", blkRdData, 8'h05);

    // R8/R9 I2C block read
    bufMode = 0; offsetIn = 8'h44;
    expectItem(P_OF, 8'h44, "R8 offset request");
    start(1, 0);
    expectItem(P_BD, 0, "R8 first byte-done");
    rsp(0, 8'h91);
    chk("R8 first byte", blkRdData, 8'h91);
    expectItem(P_RC, 0, "R8 receive request");
    bdClr();
    expectItem(P_BD, 0, "R8 byte-done 2");
    rsp(0, 8'h92);
    chk("R8 second byte", blkRdData, 8'h92);
    lastByte = 1;
    expectItem(P_RC | P_FN, 0, "R9 final receive");
    bdClr();
    lastByte = 0;
    expectItem(P_DN, 0, "R9 done");
    rsp(0, 8'h93);
    chk("R9 last byte", blkRdData, 8'h93);
    chk("R9 busy low", busy, 0);

    // R11 abandon an open I2C read (read select set: ignored per R8)
    offsetIn = 8'h05;
    expectItem(P_OF, 8'h05, "R8 offset with read bit");
    start(1, 1);
    expectItem(P_BD, 0, "R8 byte-done");
    rsp(0, 8'h66);
    hostWr(8'h55);
    countIn = 1;
    expectItem(P_ST | P_BD, 0, "R11 stop and new start");
    start(0, 0);
    expectItem(P_WR, 1, "R11 write after abandon");
    bdClr();
    mstChk(0, 8'h55, "R11 buf0");
    expectItem(P_DN, 0, "R11 done");
    rsp(0, 0);

    // R11 abandon a byte-by-byte read mid-way: index must restart
    expectItem(P_RD, 0, "R11 read request");
    start(0, 1);
    dep(0, 8'hA0); dep(1, 8'hA1);
    expectItem(P_CN | P_BD, 2, "R11 read count");
    rsp(0, 2);
    expectItem(P_BD, 0, "R11 read byte-done");
    bdClr();
    hostWr(8'h77);
    countIn = 1;
    expectItem(P_BD, 0, "R11 new write start");
    start(0, 0);
    expectItem(P_WR, 1, "R11 index restarted");
    bdClr();
    mstChk(0, 8'h77, "R11 buf0 new");
    expectItem(P_DN, 0, "R11 done 2");
    rsp(0, 0);

    // R10 index wrap in buffered mode
    bufMode = 1;
    for (int i = 0; i < 33; i++) hostWr(8'(8'h60 + i));
    countIn = 1;
    expectItem(P_WR, 1, "R10 index after wrap");
    start(0, 0);
    mstChk(0, 8'h80, "R10 wrapped entry0");
    mstChk(31, 8'h7F, "R10 last entry");
    expectItem(P_DN, 0, "R10 done");
    rsp(0, 0);

    step(); step();
    if (expQ.size() != 0) begin
      compared++;
      mismatched++;
      $display("FAIL %s: actual missing expected %0d more items", tagQ[0], expQ.size());
    end
    finished = 1;
    summary();
    $finish;
  end

endmodule